// File: doc/BRIEF.md
# Trace Buffer Write Controller

This block sits between a processor's trace source and a small on-core RAM that keeps trace records. Each record arrives with a 3-bit kind tag. A per-kind enable decides whether the record is kept. Kept records are written one word per record into a ring of RAM words. The ring runs from a programmable first slot to a programmable last slot. A write pointer walks through the ring. After the last slot is written, the pointer goes back to the first slot and a sticky wrapped flag is raised.

Four 32-bit registers configure the block: a control word, the first slot, the last slot and the write pointer. The control word sets what happens once the last slot has been written. In wrap mode the ring overwrites its oldest entries. In stop mode further records are refused. In exception mode the block emits a one-cycle exception pulse and then refuses further records. A rewind command (the discard bit) moves the pointer back to the first slot and clears both the wrapped flag and any stop. The RAM side can refuse a write through `ram_ready`. When that happens, or when a configuration write takes the cycle, a kept record is either held off with a stall request to the core or silently dropped, as selected by the stall enable.

Top module: `trace_wr_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0001, the first slot reads 0, the last slot reads 2^AW-1, the write pointer reads 0, and `ram_we`, `stall_req` and `full_exc` are low.
- R2: A record of kind k is written only when control bit 16+k is 1. A record of a disabled kind causes no write, no stall request and no pointer change.
- R3: An accepted record is written at the current pointer, with `ram_we` high in the cycle after acceptance. The pointer then advances by one. When the last slot is written, the pointer goes back to the first slot.
- R4: Control bit 24 (wrapped) becomes 1 when the last slot is written. It stays 1 until a rewind.
- R5: With control bits 9:8 = 0 (wrap), records keep being written after the ring wraps, overwriting from the first slot.
- R6: With bits 9:8 = 1 (stop) or 3 (reserved, same as stop), once the last slot is written, every later record is ignored. This means no write, no pointer change and no stall request, until a rewind.
- R7: With bits 9:8 = 2 (exception), `full_exc` is high for exactly the one cycle in which the last-slot write appears on the RAM port. Later records are then ignored, as in R6.
- R8: Writing the control word with bit 1 = 1 sets the pointer to the first slot and clears the wrapped flag and any stop. Bit 1 always reads 0.
- R9: When a kept record meets `ram_ready` = 0: if control bit 2 (stall) is 1, `stall_req` is high in that same cycle and nothing is written. If bit 2 is 0, the record is dropped with `stall_req` low.
- R10: Register selector values 0, 1, 2 and 3 select the control word, the first slot, the last slot and the write pointer. The control word reads back its enables (23:16), policy (9:8), destination (5:4) and stall (2). Bit 0 reads 1. The other registers read back their AW-bit values, zero-extended. A write to selector 3 loads the pointer.
- R11: In a cycle with `cfg_we` high, no record is accepted. A kept record in that cycle raises `stall_req` when the stall bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register selector (0 control, 1 first slot, 2 last slot, 3 pointer) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| rec_valid | input | 1 | Trace record present |
| rec_kind | input | 3 | Record kind tag |
| rec_data | input | DW | Record payload |
| ram_ready | input | 1 | RAM can take a write this cycle |
| stall_req | output | 1 | Ask the core to hold the current record |
| ram_we | output | 1 | RAM write strobe (registered) |
| ram_addr | output | AW | RAM word address (registered) |
| ram_wdata | output | DW | RAM write data (registered) |
| full_exc | output | 1 | One-cycle trace-full exception pulse |

## Verification
On every cycle, the assertions check the local rules between the decision logic and the pointer. A stopped or filtered record is never accepted. A stall and an acceptance never happen together. A configuration write always wins the cycle. The pointer moves by exactly one slot on a non-final write. A rewind lands on the first slot with the flags clear. The wrapped flag is sticky. The exception pulse never lasts two cycles. Only the bench scenarios can show the address order in RAM across a full wrap, the overwrite in wrap mode against the refusal in stop, reserved and exception modes, and the register readback images. They also show which cycle the exception pulse lines up with the final write, and how a refused RAM port splits between stalling and dropping.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  localparam int KINDS  = 8;
  localparam int KIND_W = $clog2(KINDS);

  // control word field positions (software decodes these)
  localparam int F_WRAPPED = 24;
  localparam int F_EN_LO   = 16;
  localparam int F_POL_LO  = 8;
  localparam int F_DEST_LO = 4;
  localparam int F_STALL   = 2;
  localparam int F_DISCARD = 1;
  localparam int F_IMPL    = 0;

  typedef enum logic [1:0] {
    FILL_WRAP = 2'd0,
    FILL_STOP = 2'd1,
    FILL_EXC  = 2'd2,
    FILL_RSVD = 2'd3
  } fill_pol_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_END   = 2'd2,
    SEL_WPTR  = 2'd3
  } reg_sel_e;

  function automatic logic kind_enabled(logic [KINDS-1:0] en, logic [KIND_W-1:0] k);
    return en[k];
  endfunction

  // every policy except wrap halts tracing once the last slot is used
  function automatic logic stops_when_full(fill_pol_e p);
    return p != FILL_WRAP;
  endfunction

endpackage

// File: rtl/tbw_cfg_regs.sv
module tbw_cfg_regs
  import tbw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             wrapped,
  input  logic [AW-1:0]    wptr,
  output logic [KINDS-1:0] kind_en,
  output fill_pol_e        policy,
  output logic             stall_en,
  output logic [1:0]       dest,
  output logic [AW-1:0]    start_addr,
  output logic [AW-1:0]    end_addr,
  output logic             discard,
  output logic             wptr_load,
  output logic [AW-1:0]    wptr_val,
  output logic [31:0]      cfg_rdata
);
  localparam int PAD = 32 - AW;

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     cfg_unused;

  assign sel        = reg_sel_e'(cfg_addr);
  assign ctrl_wr    = cfg_we && (sel == SEL_CTRL);
  assign discard    = ctrl_wr && cfg_wdata[F_DISCARD];
  assign wptr_load  = cfg_we && (sel == SEL_WPTR);
  assign wptr_val   = cfg_wdata[AW-1:0];
  assign cfg_unused = ^cfg_wdata;

  function automatic logic [31:0] ctrl_image(logic wr, logic [KINDS-1:0] en,
                                             fill_pol_e p, logic [1:0] d, logic st);
    logic [31:0] v;
    v = '0;
    v[F_WRAPPED]           = wr;
    v[F_EN_LO +: KINDS]    = en;
    v[F_POL_LO +: 2]       = p;
    v[F_DEST_LO +: 2]      = d;
    v[F_STALL]             = st;
    v[F_IMPL]              = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_en    <= '0;
      policy     <= FILL_WRAP;
      stall_en   <= 1'b0;
      dest       <= 2'd0;
      start_addr <= '0;
      end_addr   <= '1;
    end else begin
      if (ctrl_wr) begin
        kind_en  <= cfg_wdata[F_EN_LO +: KINDS];
        policy   <= fill_pol_e'(cfg_wdata[F_POL_LO +: 2]);
        stall_en <= cfg_wdata[F_STALL];
        dest     <= cfg_wdata[F_DEST_LO +: 2];
      end
      if (cfg_we && sel == SEL_START) start_addr <= cfg_wdata[AW-1:0];
      if (cfg_we && sel == SEL_END)   end_addr   <= cfg_wdata[AW-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  cfg_rdata = ctrl_image(wrapped, kind_en, policy, dest, stall_en);
      SEL_START: cfg_rdata = {{PAD{1'b0}}, start_addr};
      SEL_END:   cfg_rdata = {{PAD{1'b0}}, end_addr};
      default:   cfg_rdata = {{PAD{1'b0}}, wptr};
    endcase
  end

endmodule

// File: rtl/tbw_admit.sv
module tbw_admit
  import tbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [KIND_W-1:0] rec_kind,
  input  logic [KINDS-1:0]  kind_en,
  input  logic              stall_en,
  input  logic              ram_ready,
  input  logic              halted,
  input  logic              cfg_busy,
  output logic              accept,
  output logic              stall_req
);
  logic wanted;
  logic blocked;

  assign wanted    = rec_valid && kind_enabled(kind_en, rec_kind) && !halted;
  assign blocked   = !ram_ready || cfg_busy;
  assign accept    = wanted && !blocked;
  assign stall_req = wanted && blocked && stall_en;

  p_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !kind_en[rec_kind]) |-> (!accept && !stall_req));

  p_halt_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!accept && !stall_req));

  p_stall_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> !accept);

  p_cfg_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> !accept);

endmodule

// File: rtl/tbw_pointer.sv
module tbw_pointer
  import tbw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          discard,
  input  logic          wptr_load,
  input  logic [AW-1:0] wptr_val,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  fill_pol_e     policy,
  output logic [AW-1:0] wptr,
  output logic          wrapped,
  output logic          halted,
  output logic          full_exc
);
  logic at_end;
  logic last_write;

  function automatic logic [AW-1:0] ring_next(logic [AW-1:0] p, logic [AW-1:0] s,
                                              logic [AW-1:0] e);
    return (p == e) ? s : p + 1'b1;
  endfunction

  assign at_end     = (wptr == end_addr);
  assign last_write = accept && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wrapped  <= 1'b0;
      halted   <= 1'b0;
      full_exc <= 1'b0;
    end else begin
      full_exc <= last_write && (policy == FILL_EXC);
      if (discard) begin
        wptr    <= start_addr;
        wrapped <= 1'b0;
        halted  <= 1'b0;
      end else if (wptr_load) begin
        wptr <= wptr_val;
      end else if (accept) begin
        wptr <= ring_next(wptr, start_addr, end_addr);
        if (at_end) begin
          wrapped <= 1'b1;
          if (stops_when_full(policy)) halted <= 1'b1;
        end
      end
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !at_end) |=> (wptr == AW'($past(wptr) + 1'b1)));

  p_wrap_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_write |=> (wptr == $past(start_addr) && wrapped));

  p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !discard) |=> wrapped);

  p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (wptr == $past(start_addr) && !wrapped && !halted));

  p_exc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_exc |=> !full_exc);

endmodule

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl
  import tbw_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              rec_valid,
  input  logic [KIND_W-1:0] rec_kind,
  input  logic [DW-1:0]     rec_data,
  input  logic              ram_ready,
  output logic              stall_req,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              full_exc
);
  logic [KINDS-1:0] kind_en;
  fill_pol_e        policy;
  logic             stall_en;
  logic [1:0]       dest;
  logic [AW-1:0]    start_addr, end_addr, wptr, wptr_val;
  logic             discard, wptr_load, wrapped, halted, accept;

  tbw_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wrapped(wrapped), .wptr(wptr),
    .kind_en(kind_en), .policy(policy), .stall_en(stall_en), .dest(dest),
    .start_addr(start_addr), .end_addr(end_addr), .discard(discard),
    .wptr_load(wptr_load), .wptr_val(wptr_val), .cfg_rdata(cfg_rdata)
  );

  tbw_admit u_admit (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .kind_en(kind_en), .stall_en(stall_en), .ram_ready(ram_ready),
    .halted(halted), .cfg_busy(cfg_we), .accept(accept), .stall_req(stall_req)
  );

  tbw_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .discard(discard),
    .wptr_load(wptr_load), .wptr_val(wptr_val), .start_addr(start_addr),
    .end_addr(end_addr), .policy(policy), .wptr(wptr), .wrapped(wrapped),
    .halted(halted), .full_exc(full_exc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= accept;
      if (accept) begin
        ram_addr  <= wptr;
        ram_wdata <= rec_data;
      end
    end
  end

  p_write_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ram_we && ram_addr == $past(wptr)));

  p_no_spurious_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !ram_we);

  p_exc_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_exc |-> ram_we);

endmodule

// File: tb/trace_wr_ctrl_tb.sv
module trace_wr_ctrl_tb;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic rec_valid = 1'b0;
  logic [2:0] rec_kind = '0;
  logic [DW-1:0] rec_data = '0;
  logic ram_ready = 1'b1;
  logic stall_req, ram_we, full_exc;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [AW+DW-1:0] exp_q[$];
  logic [AW-1:0] m_start = '0, m_end = '1, m_ptr = '0;
  bit m_wrap = 0, m_halt = 0, m_stall = 0, exc_pending = 0;
  logic [7:0] m_en = '0;
  logic [1:0] m_pol = '0, m_dest = '0;

  always #5 clk = ~clk;

  trace_wr_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rec_valid(rec_valid),
    .rec_kind(rec_kind), .rec_data(rec_data), .ram_ready(ram_ready),
    .stall_req(stall_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .full_exc(full_exc)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(logic [7:0] en, logic [1:0] pol, bit st,
                                          logic [1:0] d, bit disc);
    return (32'(en) << 16) | (32'(pol) << 8) | (32'(d) << 4) | (32'(st) << 2)
           | (32'(disc) << 1);
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return (32'(m_wrap) << 24) | mk_ctrl(m_en, m_pol, m_stall, m_dest, 1'b0) | 32'd1;
  endfunction

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    case (a)
      2'd0: begin
        m_en = d[23:16]; m_pol = d[9:8]; m_stall = d[2]; m_dest = d[5:4];
        if (d[1]) begin m_ptr = m_start; m_wrap = 0; m_halt = 0; end
      end
      2'd1: m_start = d[AW-1:0];
      2'd2: m_end = d[AW-1:0];
      default: m_ptr = d[AW-1:0];
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(logic [1:0] a, logic [31:0] e, string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic send(logic [2:0] k, logic [31:0] d, bit rdy, string req);
    bit want, acc, st;
    @(negedge clk);
    rec_valid = 1'b1; rec_kind = k; rec_data = d; ram_ready = rdy;
    want = m_en[k] && !m_halt;
    acc  = want && rdy;
    st   = want && !rdy && m_stall;
    #1;
    chk(stall_req == st, req, stall_req, st);
    if (acc) begin
      exp_q.push_back({m_ptr, d});
      if (m_ptr == m_end) begin
        m_wrap = 1;
        if (m_pol != 2'd0) m_halt = 1;
        if (m_pol == 2'd2) exc_pending = 1;
        m_ptr = m_start;
      end else begin
        m_ptr = m_ptr + 1'b1;
      end
    end
    @(negedge clk);
    rec_valid = 1'b0; ram_ready = 1'b1;
  endtask

  // record sent in the same cycle as a register write (R11)
  task automatic send_during_cfg(logic [2:0] k, logic [31:0] d);
    bit st;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'(m_start);
    rec_valid = 1'b1; rec_kind = k; rec_data = d; ram_ready = 1'b1;
    st = m_en[k] && !m_halt && m_stall;
    #1;
    chk(stall_req == st, "R11 stall during cfg write", stall_req, st);
    @(negedge clk);
    cfg_we = 1'b0; rec_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", {ram_addr, ram_wdata}, 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          chk({ram_addr, ram_wdata} == e, "R3 write addr/data", {ram_addr, ram_wdata}, e);
        end
      end
      if (full_exc || exc_pending) begin
        chk(full_exc == exc_pending, "R7 exception pulse", full_exc, exc_pending);
        exc_pending = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ram_we == 0 && stall_req == 0 && full_exc == 0, "R1 outputs idle",
        {ram_we, stall_req, full_exc}, 0);
    rst_n = 1'b1;
    cfg_check(2'd0, 32'h1, "R1 ctrl reset");
    cfg_check(2'd1, 32'h0, "R1 start reset");
    cfg_check(2'd2, 32'h3FF, "R1 end reset");
    cfg_check(2'd3, 32'h0, "R1 wptr reset");

    // R10: register map and readback; enable kinds 0 and 2, stall on, destination 1
    cfg_write(2'd0, mk_ctrl(8'h05, 2'd0, 1, 2'd1, 0));
    cfg_check(2'd0, exp_ctrl(), "R10 ctrl readback");
    cfg_write(2'd1, 32'd8);
    cfg_write(2'd2, 32'd11);
    cfg_check(2'd1, 32'd8, "R10 start readback");
    cfg_check(2'd2, 32'd11, "R10 end readback");
    cfg_write(2'd3, 32'd5);
    cfg_check(2'd3, 32'd5, "R10 wptr load");
    cfg_write(2'd0, mk_ctrl(8'h05, 2'd0, 1, 2'd1, 1));
    cfg_check(2'd3, 32'd8, "R8 discard to start");

    // R2 filter, R3 ordering, R4 wrap, R5 overwrite
    send(3'd0, 32'hA000_0001, 1, "R3 stall low");
    send(3'd1, 32'hBAD0_0001, 1, "R2 disabled kind no stall");
    cfg_check(2'd3, 32'd9, "R2 pointer unchanged by disabled kind");
    send(3'd2, 32'hA000_0002, 1, "R3 stall low");
    send(3'd0, 32'hA000_0003, 1, "R3 stall low");
    cfg_check(2'd0, exp_ctrl(), "R4 not wrapped yet");
    send(3'd0, 32'hA000_0004, 1, "R3 stall low");
    cfg_check(2'd0, exp_ctrl(), "R4 wrapped set");
    cfg_check(2'd3, 32'd8, "R3 pointer back to start");
    send(3'd2, 32'hA000_0005, 1, "R5 overwrite");
    cfg_check(2'd0, exp_ctrl(), "R4 wrapped sticky");

    // R9 refused RAM port
    send(3'd0, 32'hBAD0_0002, 0, "R9 stall when ram busy");
    cfg_write(2'd0, mk_ctrl(8'h05, 2'd0, 0, 2'd1, 0));
    send(3'd0, 32'hBAD0_0003, 0, "R9 drop without stall");
    cfg_check(2'd3, 32'd9, "R9 pointer unchanged by refused record");

    // R11 register write wins the cycle
    cfg_write(2'd0, mk_ctrl(8'h05, 2'd0, 1, 2'd1, 0));
    send_during_cfg(3'd0, 32'hBAD0_0004);
    cfg_check(2'd3, 32'd9, "R11 pointer unchanged");

    // R8 rewind
    cfg_write(2'd0, mk_ctrl(8'hFF, 2'd1, 1, 2'd0, 1));
    cfg_check(2'd0, exp_ctrl(), "R8 wrapped cleared, discard reads 0");
    cfg_check(2'd3, 32'd8, "R8 pointer at start");

    // R6 stop mode
    for (int i = 0; i < 4; i++) send(3'(i + 3), 32'hC000_0000 + i, 1, "R6 fill");
    send(3'd7, 32'hBAD0_0005, 1, "R6 ignored no stall");
    send(3'd0, 32'hBAD0_0006, 0, "R6 ignored no stall when busy");
    cfg_check(2'd3, 32'd8, "R6 pointer frozen");

    // R6 reserved policy behaves as stop
    cfg_write(2'd0, mk_ctrl(8'hFF, 2'd3, 1, 2'd0, 1));
    for (int i = 0; i < 4; i++) send(3'(i), 32'hD000_0000 + i, 1, "R6 reserved fill");
    send(3'd1, 32'hBAD0_0007, 1, "R6 reserved ignored");

    // R7 exception mode
    cfg_write(2'd0, mk_ctrl(8'hFF, 2'd2, 1, 2'd0, 1));
    for (int i = 0; i < 4; i++) send(3'(i), 32'hE000_0000 + i, 1, "R7 fill");
    send(3'd2, 32'hBAD0_0008, 1, "R7 ignored after exception");
    cfg_check(2'd0, exp_ctrl(), "R7 wrapped after exception fill");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule